// File: doc/BRIEF.md
# Backlight PWM Generator

This block drives a display backlight with one pulse-width-modulated pin. Software programs it through a small word-addressed write port. A control word holds an enable bit, an output inversion bit and a prescale select. A period word holds the maximum count in its upper half. A duty word holds the active count in its lower half.

A prescaler advances the period counter once every 16 or once every 128 reference clocks. One PWM period therefore lasts maximum count × granularity reference clocks. The pin is active for the first min(duty, maximum) counter steps of each period.

Software writes the period and polarity first and then sets enable in a separate write. The duty value may follow after enable is set. The generator copies all settings into working copies when it starts, and again only at each period boundary, so a reprogrammed value never cuts a pulse short.

Top module: `bl_pwm_gen`

## Requirements
- R1: Writes use address 0 for control, with enable at bit 31, inversion at bit 29 and prescale select at bit 0. Address 1 takes the maximum count from bits 31:16. Address 2 takes the duty from bits 15:0.
- R2: While enable is clear, the pin sits at the inactive level, which equals the inversion bit. The prescaler and the period counter are held at zero.
- R3: The first period starts two clock edges after the write that sets enable. Each period lasts maximum × granularity clocks. The pin is active for the first min(duty, maximum) × granularity clocks of the period.
- R4: Prescale select 0 gives a granularity of 16 reference clocks per count, and select 1 gives 128.
- R5: With the inversion bit set, the active level is low and the inactive level is high. With it clear, the active level is high.
- R6: A duty of zero keeps the pin inactive for the whole period. A duty equal to or above the maximum keeps the pin active for the whole period.
- R7: A maximum count of zero keeps the pin inactive while enabled.
- R8: Maximum count, duty, inversion and prescale select are captured when enable rises. Later writes to any of them take effect only at the next period boundary.
- R9: During and right after reset, all settings are zero and the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Word select: 0 control, 1 period, 2 duty |
| wr_data | input | 32 | Write data |
| pwm_out | output | 1 | Backlight PWM pin |

## Verification
The embedded assertions check several properties on every cycle:
- the prescaler and counter stay inside their bounds;
- both are cleared while the generator is disabled;
- prescale ticks never come back to back;
- the working copies hold still between period boundaries;
- a zero maximum leaves the pin at its inactive level.

Only the bench's scenarios can show the actual waveform: the pulse width and period for each duty, maximum, granularity and polarity combination. They also show that a write made mid-period lands exactly one boundary later and that the first period starts at the expected cycle. The bench sweeps small maximum counts against every duty up to one beyond the maximum, both polarities and both granularities.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;
  parameter int unsigned BL_CNT_W = 16;

  localparam int unsigned BIT_ENABLE = 31;
  localparam int unsigned BIT_INVERT = 29;
  localparam int unsigned BIT_GSEL   = 0;
  localparam int unsigned MAX_LSB    = 16;
  localparam int unsigned DUTY_LSB   = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_DUTY   = 2'd2,
    ADDR_NONE   = 2'd3
  } bl_addr_e;

  typedef struct packed {
    logic                enable;
    logic                invert;
    logic                gsel;
    logic [BL_CNT_W-1:0] max_cnt;
    logic [BL_CNT_W-1:0] duty;
  } bl_cfg_t;
endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
  import bl_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output bl_cfg_t     cfg_o
);
  bl_cfg_t cfg_q, cfg_d;
  logic    ld_ctrl, ld_period, ld_duty;

  always_comb begin
    ld_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    ld_period = wr_en && (wr_addr == ADDR_PERIOD);
    ld_duty   = wr_en && (wr_addr == ADDR_DUTY);
    cfg_d     = cfg_q;
    if (ld_ctrl) begin
      cfg_d.enable = wr_data[BIT_ENABLE];
      cfg_d.invert = wr_data[BIT_INVERT];
      cfg_d.gsel   = wr_data[BIT_GSEL];
    end
    if (ld_period) cfg_d.max_cnt = wr_data[MAX_LSB +: BL_CNT_W];
    if (ld_duty)   cfg_d.duty    = wr_data[DUTY_LSB +: BL_CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ld_ctrl || ld_period || ld_duty) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  AST_WRITE_ONLY_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q)) else $error("cfg changed without write"); // R1
endmodule

// File: rtl/bl_pwm_prescale.sv
module bl_pwm_prescale #(
  parameter int unsigned FINE   = 16,
  parameter int unsigned COARSE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic gsel_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = $clog2(COARSE);
  localparam logic [PRE_W-1:0] FINE_LAST   = PRE_W'(FINE - 1);
  localparam logic [PRE_W-1:0] COARSE_LAST = PRE_W'(COARSE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] last;

  always_comb begin
    last   = gsel_i ? COARSE_LAST : FINE_LAST;
    tick_o = run_i && (pre_q == last);
    if (!run_i)      pre_d = '0;
    else if (tick_o) pre_d = '0;
    else             pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= last) else $error("prescaler beyond limit"); // R4
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> pre_q == '0) else $error("prescaler moved while idle"); // R2
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o) else $error("back to back ticks"); // R4
endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
  import bl_pwm_pkg::*;
#(
  parameter int unsigned FINE   = 16,
  parameter int unsigned COARSE = 128
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bl_cfg_t cfg_i,
  output logic    pwm_o
);
  typedef logic [BL_CNT_W-1:0] cnt_t;

  logic run_q, run_d;
  cnt_t cnt_q, cnt_d;
  cnt_t act_max_q, act_duty_q;
  logic act_inv_q, act_gsel_q;
  logic live, start, tick, wrap, load;
  cnt_t eff_duty;
  logic active, out_inv;

  bl_pwm_prescale #(.FINE(FINE), .COARSE(COARSE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (live),
    .gsel_i (act_gsel_q),
    .tick_o (tick)
  );

  always_comb begin
    live  = run_q && cfg_i.enable;
    start = cfg_i.enable && !run_q;
    wrap  = tick && ((act_max_q == '0) || (cnt_q == act_max_q - 1'b1));
    load  = start || (live && wrap);
    run_d = cfg_i.enable;
    if (!cfg_i.enable) cnt_d = '0;
    else if (load)     cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + 1'b1;
    else               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_max_q  <= '0;
      act_duty_q <= '0;
      act_inv_q  <= 1'b0;
      act_gsel_q <= 1'b0;
    end else if (load) begin
      act_max_q  <= cfg_i.max_cnt;
      act_duty_q <= cfg_i.duty;
      act_inv_q  <= cfg_i.invert;
      act_gsel_q <= cfg_i.gsel;
    end
  end

  always_comb begin
    eff_duty = (act_duty_q > act_max_q) ? act_max_q : act_duty_q;
    active   = live && (act_max_q != '0) && (cnt_q < eff_duty);
    out_inv  = live ? act_inv_q : cfg_i.invert;
    pwm_o    = active ^ out_inv;
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.enable |=> cnt_q == '0) else $error("counter moved while idle"); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_max_q != '0) |-> cnt_q < act_max_q) else $error("counter beyond max"); // R3
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !wrap) |=> ($stable(act_max_q) && $stable(act_duty_q) && $stable(act_inv_q)))
    else $error("working copy changed mid-period"); // R8
  AST_ZERO_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (live && act_max_q == '0) |-> pwm_o == act_inv_q) else $error("zero max drove active"); // R7
endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen
  import bl_pwm_pkg::*;
#(
  parameter int unsigned FINE   = 16,
  parameter int unsigned COARSE = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic        pwm_out
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  bl_cfg_t    cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bl_pwm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_o   (cfg)
  );

  bl_pwm_core #(.FINE(FINE), .COARSE(COARSE)) u_core (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cfg_i (cfg),
    .pwm_o (pwm_out)
  );

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!cfg.enable && $past(!cfg.enable)) |-> pwm_out == cfg.invert)
    else $error("idle level wrong"); // R2
endmodule

// File: tb/bl_pwm_gen_tb_top.sv
module bl_pwm_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  bl_pwm_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pwm_out=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit inv, input bit g);
    return (32'(en) << 31) | (32'(inv) << 29) | 32'(g);
  endfunction

  function automatic logic expv(input int k, input int m, input int d, input bit inv, input int gr);
    int eff;
    eff = (d > m) ? m : d;
    if (m == 0) return inv;
    return (((k / gr) % m) < eff) ? ~inv : inv;
  endfunction

  // Enables with (m,d,inv,g); optionally writes at interval kw to change
  // settings, which must show from the next boundary as (m2,d2,inv2).
  task automatic run_cfg(input int m, input int d, input bit inv, input bit g,
                         input int kw, input logic [1:0] wa, input logic [31:0] wd,
                         input int m2, input int d2, input bit inv2, input string req);
    int gr, p0, tot;
    gr = g ? 128 : 16;
    wr(2'd0, ctl(1'b0, inv, g));
    chk(pwm_out, inv, "R2");
    wr(2'd1, 32'(m) << 16);
    wr(2'd2, 32'(d));
    wr(2'd0, ctl(1'b1, inv, g));
    chk(pwm_out, inv, "R3");
    @(negedge clk);
    p0  = (m == 0) ? gr : m * gr;
    tot = p0 + 2 * ((m2 == 0) ? gr : m2 * gr);
    for (int k = 0; k < tot; k++) begin
      if (k < p0) chk(pwm_out, expv(k, m, d, inv, gr), req);
      else        chk(pwm_out, expv(k - p0, m2, d2, inv2, gr), req);
      if (k == kw) begin
        wr_en = 1'b1; wr_addr = wa; wr_data = wd;
      end
      if (k == kw + 1) wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    wr(2'd0, ctl(1'b0, inv2, g));
    chk(pwm_out, inv2, "R2");
    @(negedge clk);
    chk(pwm_out, inv2, "R2");
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: pwm_out=%0b expected=finish", pwm_out);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(pwm_out, 1'b0, "R9");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwm_out, 1'b0, "R9");

    // R3 R5 R6: sweep max, duty up to max+1, both polarities, fine steps
    for (int m = 1; m <= 5; m++)
      for (int d = 0; d <= m + 1; d++)
        for (int p = 0; p < 2; p++)
          run_cfg(m, d, bit'(p), 1'b0, -5, 2'd0, 0, m, d, bit'(p), "R3_R5_R6");

    // R4: coarse granularity
    run_cfg(3, 1, 1'b0, 1'b1, -5, 2'd0, 0, 3, 1, 1'b0, "R4");
    run_cfg(2, 1, 1'b1, 1'b1, -5, 2'd0, 0, 2, 1, 1'b1, "R4");
    // R6: very large duty clamps to the max
    run_cfg(3, 16'hFFFF, 1'b0, 1'b0, -5, 2'd0, 0, 3, 16'hFFFF, 1'b0, "R6");
    // R7: zero max stays inactive
    run_cfg(0, 5, 1'b0, 1'b0, -5, 2'd0, 0, 0, 5, 1'b0, "R7");
    run_cfg(0, 5, 1'b1, 1'b0, -5, 2'd0, 0, 0, 5, 1'b1, "R7");
    // R8: duty written right after enable, and mid-period
    run_cfg(4, 1, 1'b0, 1'b0, 0, 2'd2, 32'd3, 4, 3, 1'b0, "R8");
    run_cfg(4, 3, 1'b0, 1'b0, 20, 2'd2, 32'd0, 4, 0, 1'b0, "R8");
    // R8: period change mid-period
    run_cfg(3, 2, 1'b0, 1'b0, 5, 2'd1, 32'd5 << 16, 5, 2, 1'b0, "R8");
    // R8 R1: polarity change while running
    run_cfg(2, 1, 1'b0, 1'b0, 3, 2'd0, ctl(1'b1, 1'b1, 1'b0), 2, 1, 1'b1, "R8");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule